// File: doc/BRIEF.md
# Ordered Store Buffer with Barrier Marking

This block sits between a core's store port and its private cache. When a store targets a line the core does not yet hold exclusively, the store is put in a small in-order queue and the core keeps running. When the line is already owned, the store goes straight to the cache through a direct write port. Loads look in the queue first. If a load address matches a queued store, the block returns the newest queued value, so the core always reads back its own latest write.

The coherence side is modelled by two ports. The first is an ownership request for the oldest queued entry that is still waiting. The second is an acknowledge carrying a line address; it grants ownership to every queued entry for that line. Entries leave the queue strictly from the oldest end, and only once their line has been granted. Each leaving entry appears on a drain write port toward the cache.

A full-barrier input flags every entry present at that moment. While any flagged entry remains, new stores are queued even when their line is owned. Because the queue drains in order, the flagged stores become visible before anything issued after the barrier. A status output shows that flagged entries are still outstanding.

Top module: `store_buffer_ord`

## Requirements
- R1: A store accepted with `st_owned` low is placed in the queue and not written directly (`dir_wr_valid` stays low). `st_ready` is high whenever the queue holds fewer than DEPTH (default 8) entries.
- R2: A store accepted with `st_owned` high is written through `dir_wr_*` in the same cycle, and is not queued, when all of these hold: no flagged entry exists, no barrier is being applied to a non-empty queue, and no queued entry has the same address.
- R3: With `ld_addr` matching a queued entry, `ld_hit` is high and `ld_data` gives the queued data in the same cycle. With no match, `ld_hit` is low.
- R4: When several queued entries match the load address, `ld_data` comes from the youngest of them.
- R5: An acknowledge on `ack_valid`/`ack_addr` grants every queued entry with that address. The oldest entry is shown on `drn_*` in the cycle after its grant, and leaves the queue at the end of that cycle.
- R6: A `barrier` pulse flags every entry in the queue. `bar_pending` is high from the next cycle. A barrier applied to an empty queue leaves `bar_pending` low, and owned stores still go direct.
- R7: While `bar_pending` is high, an owned store is queued instead of written directly. It is queued already granted.
- R8: Entries drain in program order. A granted younger entry waits behind an ungranted older one, so no entry issued after a barrier drains before a flagged one.
- R9: `bar_pending` stays high until the last flagged entry has drained, and falls in the cycle after that drain.
- R10: With DEPTH entries queued, `st_ready` is low. A store presented then is ignored: it is neither written directly nor queued.
- R11: `req_valid` is high with `req_addr` equal to the oldest entry's address while that entry is queued and not yet granted.
- R12: An owned store whose address matches a queued entry is queued behind it rather than written directly, so the cache receives the two values in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request from the core |
| st_addr | input | ADDR_W | Store line address |
| st_data | input | DATA_W | Store data |
| st_owned | input | 1 | Line is currently held exclusively |
| st_ready | output | 1 | Queue can take a store |
| barrier | input | 1 | Full-barrier pulse |
| bar_pending | output | 1 | Flagged entries still queued |
| ld_addr | input | ADDR_W | Load lookup address |
| ld_hit | output | 1 | Load matches a queued store |
| ld_data | output | DATA_W | Forwarded data |
| dir_wr_valid | output | 1 | Direct cache write |
| dir_wr_addr | output | ADDR_W | Direct write address |
| dir_wr_data | output | DATA_W | Direct write data |
| drn_valid | output | 1 | Oldest entry drains to the cache |
| drn_addr | output | ADDR_W | Drain address |
| drn_data | output | DATA_W | Drain data |
| req_valid | output | 1 | Ownership request for oldest entry |
| req_addr | output | ADDR_W | Requested line |
| ack_valid | input | 1 | All acknowledgments for a line received |
| ack_addr | input | ADDR_W | Line being granted |

## Verification
The bench grants a young owned entry while an older flagged entry is still waiting. A design that drained whatever was granted would let the post-barrier store out first. Two stores to one address are checked in both directions: a forwarding search that returns the oldest match would return stale data, and a direct write that ignores queued entries would let the cache be overwritten by the older value later. Other targets are a barrier on an empty queue, which a sloppy design would leave stuck pending, and a store offered to a full queue, which a weak full check would silently drop or write through.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic  valid;
        logic  marked;
        logic  granted;
        addr_t addr;
        data_t data;
    } sb_entry_t;
endpackage

// File: rtl/sb_fwd.sv
// Youngest-match search over the queue, oldest to youngest by age.
module sb_fwd
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  sb_entry_t        ents_i [DEPTH],
    input  logic [IDX_W-1:0] head_i,
    input  addr_t            addr_i,
    output logic             hit_o,
    output data_t            data_o
);
    logic [IDX_W-1:0] age_idx [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_age
        logic [IDX_W:0] s;
        assign s = {1'b0, head_i} + (IDX_W+1)'(k);
        assign age_idx[k] = (s >= (IDX_W+1)'(DEPTH)) ? IDX_W'(s - (IDX_W+1)'(DEPTH)) : IDX_W'(s);
    end

    always_comb begin
        hit_o  = 1'b0;
        data_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (ents_i[age_idx[k]].valid && ents_i[age_idx[k]].addr == addr_i) begin
                hit_o  = 1'b1;
                data_o = ents_i[age_idx[k]].data;   // later (younger) match wins
            end
        end
    end
endmodule

// File: rtl/sb_queue.sv
// In-order entry storage with grant and barrier flags.
module sb_queue
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  addr_t            push_addr_i,
    input  data_t            push_data_i,
    input  logic             push_granted_i,
    input  logic             barrier_i,
    input  logic             ack_valid_i,
    input  addr_t            ack_addr_i,
    output sb_entry_t        ents_o [DEPTH],
    output logic [IDX_W-1:0] head_o,
    output logic [CNT_W-1:0] count_o,
    output sb_entry_t        head_ent_o,
    output logic             pop_o,
    output logic             full_o,
    output logic             pending_o
);
    sb_entry_t        ents [DEPTH];
    logic [IDX_W-1:0] head, tail, head_nx;
    logic [CNT_W-1:0] count;
    logic [IDX_W:0]   tail_sum;

    assign tail_sum   = {1'b0, head} + (IDX_W+1)'(count);
    assign tail       = (tail_sum >= (IDX_W+1)'(DEPTH)) ? IDX_W'(tail_sum - (IDX_W+1)'(DEPTH)) : IDX_W'(tail_sum);
    assign head_nx    = (head == IDX_W'(DEPTH-1)) ? '0 : head + 1'b1;
    assign head_ent_o = ents[head];
    assign pop_o      = ents[head].valid && ents[head].granted;
    assign full_o     = (count == CNT_W'(DEPTH));

    always_comb begin
        pending_o = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            pending_o = pending_o | (ents[i].valid & ents[i].marked);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
            head  <= '0;
            count <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ents[i].valid && ack_valid_i && ents[i].addr == ack_addr_i)
                    ents[i].granted <= 1'b1;
                if (ents[i].valid && barrier_i)
                    ents[i].marked <= 1'b1;
            end
            if (pop_o) begin
                ents[head].valid <= 1'b0;
                head             <= head_nx;
            end
            if (push_i)
                ents[tail] <= '{valid: 1'b1, marked: 1'b0, granted: push_granted_i,
                                addr: push_addr_i, data: push_data_i};
            count <= count + CNT_W'(push_i) - CNT_W'(pop_o);
        end
    end

    assign ents_o  = ents;
    assign head_o  = head;
    assign count_o = count;
endmodule

// File: rtl/store_buffer_ord.sv
module store_buffer_ord
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              st_owned,
    output logic              st_ready,
    input  logic              barrier,
    output logic              bar_pending,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    output logic              dir_wr_valid,
    output logic [ADDR_W-1:0] dir_wr_addr,
    output logic [DATA_W-1:0] dir_wr_data,
    output logic              drn_valid,
    output logic [ADDR_W-1:0] drn_addr,
    output logic [DATA_W-1:0] drn_data,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              ack_valid,
    input  logic [ADDR_W-1:0] ack_addr
);
    sb_entry_t        ents [DEPTH];
    sb_entry_t        head_ent;
    logic [IDX_W-1:0] head;
    logic [CNT_W-1:0] count;
    logic             full, pending, pop;
    logic             st_match, st_acc, mark_now, go_direct, push;
    data_t            st_match_data;

    sb_queue #(.DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst(rst),
        .push_i(push), .push_addr_i(st_addr), .push_data_i(st_data), .push_granted_i(st_owned),
        .barrier_i(barrier), .ack_valid_i(ack_valid), .ack_addr_i(ack_addr),
        .ents_o(ents), .head_o(head), .count_o(count), .head_ent_o(head_ent),
        .pop_o(pop), .full_o(full), .pending_o(pending)
    );

    sb_fwd #(.DEPTH(DEPTH)) u_ld_fwd (
        .ents_i(ents), .head_i(head), .addr_i(ld_addr), .hit_o(ld_hit), .data_o(ld_data)
    );

    sb_fwd #(.DEPTH(DEPTH)) u_st_match (
        .ents_i(ents), .head_i(head), .addr_i(st_addr), .hit_o(st_match), .data_o(st_match_data)
    );

    // A barrier arriving with the store flags the existing entries this same edge.
    assign mark_now  = barrier && (count != '0);
    assign st_ready  = !full;
    assign st_acc    = st_valid && st_ready;
    assign go_direct = st_acc && st_owned && !pending && !mark_now && !st_match;
    assign push      = st_acc && !go_direct;

    assign dir_wr_valid = go_direct;
    assign dir_wr_addr  = st_addr;
    assign dir_wr_data  = st_data;

    assign drn_valid = pop;
    assign drn_addr  = head_ent.addr;
    assign drn_data  = head_ent.data;

    assign req_valid = head_ent.valid && !head_ent.granted;
    assign req_addr  = head_ent.addr;

    assign bar_pending = pending;

    assert_unowned_queued_R1: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_ready && !st_owned) |-> !dir_wr_valid);

    assert_mark_sets_pending_R6: assert property (@(posedge clk) disable iff (rst)
        (barrier && count != '0) |=> bar_pending);

    assert_barrier_blocks_direct_R7: assert property (@(posedge clk) disable iff (rst)
        bar_pending |-> !dir_wr_valid);

    assert_flagged_first_R8: assert property (@(posedge clk) disable iff (rst)
        (drn_valid && !head_ent.marked) |-> !bar_pending);

    assert_pending_falls_on_drain_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(bar_pending) |-> $past(drn_valid));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        (!st_ready && !drn_valid) |=> !st_ready);

    assert_same_line_queued_R12: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_match) |-> !dir_wr_valid);
endmodule

// File: tb/sim_store_buffer_ord.sv
`timescale 1ns/1ps
module sim_store_buffer_ord;
    import sb_pkg::*;

    logic clk = 1'b0, rst = 1'b1;
    logic st_valid = 0, st_owned = 0, barrier = 0, ack_valid = 0;
    logic [ADDR_W-1:0] st_addr = '0, ld_addr = '0, ack_addr = '0;
    logic [DATA_W-1:0] st_data = '0;
    logic st_ready, bar_pending, ld_hit, dir_wr_valid, drn_valid, req_valid;
    logic [ADDR_W-1:0] dir_wr_addr, drn_addr, req_addr;
    logic [DATA_W-1:0] ld_data, dir_wr_data, drn_data;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [ADDR_W-1:0] log_a [64];
    logic [DATA_W-1:0] log_d [64];
    int log_n = 0;
    logic dirv;
    logic hit;
    logic [DATA_W-1:0] dat;

    always #2.5 clk = ~clk;

    store_buffer_ord u0 (.*);

    always @(negedge clk) if (!rst && drn_valid && log_n < 64) begin
        log_a[log_n] = drn_addr; log_d[log_n] = drn_data; log_n++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic st(input logic [15:0] a, input logic [31:0] d, input logic own);
        st_valid = 1; st_addr = a; st_data = d; st_owned = own;
        #1 dirv = dir_wr_valid;
        @(negedge clk); st_valid = 0;
    endtask

    task automatic ld(input logic [15:0] a);
        ld_addr = a; #1 hit = ld_hit; dat = ld_data;
    endtask

    task automatic ack(input logic [15:0] a);
        ack_valid = 1; ack_addr = a; @(negedge clk); ack_valid = 0;
    endtask

    task automatic bar();
        barrier = 1; @(negedge clk); barrier = 0;
    endtask

    task automatic t_reset();
        chk("R1 ready after reset", st_ready, 1);
        chk("R9 pending after reset", bar_pending, 0);
        chk("R5 no drain after reset", drn_valid, 0);
        chk("R11 no request after reset", req_valid, 0);
        ld(16'h10); chk("R3 miss after reset", hit, 0);
    endtask

    task automatic t_basic();
        int b = log_n;
        st(16'h10, 32'h11, 0); chk("R1 unowned not direct", dirv, 0);
        ld(16'h10); chk("R3 hit", hit, 1); chk("R3 data", dat, 32'h11);
        chk("R11 req valid", req_valid, 1); chk("R11 req addr", req_addr, 16'h10);
        st(16'h20, 32'h22, 1); chk("R2 owned direct", dirv, 1);
        ld(16'h20); chk("R2 not queued", hit, 0);
        st(16'h10, 32'h33, 0);
        ld(16'h10); chk("R4 youngest match", dat, 32'h33);
        chk("R5 no drain before ack", drn_valid, 0);
        ack(16'h10);
        #1 chk("R5 drain next cycle", drn_valid, 1);
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R5 two drains", log_n - b, 2);
        chk("R5 first addr", log_a[b], 16'h10); chk("R5 first data", log_d[b], 32'h11);
        chk("R5 second data", log_d[b+1], 32'h33);
        ld(16'h10); chk("R5 removed after drain", hit, 0);
        chk("R11 idle request", req_valid, 0);
    endtask

    task automatic t_barrier();
        int b = log_n;
        st(16'h40, 32'hA1, 0);
        bar(); #1 chk("R6 pending after barrier", bar_pending, 1);
        st(16'h50, 32'hA2, 1); chk("R7 owned store queued", dirv, 0);
        ld(16'h50); chk("R7 forwarded", dat, 32'hA2);
        repeat (3) @(negedge clk);
        #1 chk("R9 pending held", bar_pending, 1);
        chk("R8 granted young waits", log_n - b, 0);
        chk("R11 req for flagged", req_addr, 16'h40);
        ack(16'h40);
        #1 chk("R9 high while last flagged drains", bar_pending, 1);
        @(negedge clk); #1 chk("R9 falls after drain", bar_pending, 0);
        @(negedge clk); @(negedge clk);
        chk("R8 order count", log_n - b, 2);
        chk("R8 flagged first", log_a[b], 16'h40);
        chk("R8 post-barrier second", log_a[b+1], 16'h50);
    endtask

    task automatic t_empty_barrier();
        bar(); #1 chk("R6 empty barrier no pending", bar_pending, 0);
        st(16'h70, 32'hB0, 1); chk("R6 direct after empty barrier", dirv, 1);
    endtask

    task automatic t_same_addr();
        int b = log_n;
        st(16'h60, 32'hC1, 0);
        st(16'h60, 32'hC2, 1); chk("R12 same line queued", dirv, 0);
        ld(16'h60); chk("R12 newest forwarded", dat, 32'hC2);
        ack(16'h60); repeat (3) @(negedge clk);
        chk("R12 both drained", log_n - b, 2);
        chk("R12 old first", log_d[b], 32'hC1);
        chk("R12 new second", log_d[b+1], 32'hC2);
    endtask

    task automatic t_full();
        int b = log_n;
        for (int i = 0; i < 8; i++) st(16'h100 + 16'(i), 32'(i), 0);
        chk("R10 ready low when full", st_ready, 0);
        st(16'h200, 32'hDD, 1); chk("R10 full store not direct", dirv, 0);
        ld(16'h200); chk("R10 full store dropped", hit, 0);
        ack(16'h107); @(negedge clk); @(negedge clk);
        chk("R8 youngest granted waits", log_n - b, 0);
        for (int i = 0; i < 7; i++) ack(16'h100 + 16'(i));
        repeat (4) @(negedge clk);
        chk("R8 all drained", log_n - b, 8);
        for (int i = 0; i < 8; i++) chk("R8 program order", log_a[b+i], 16'h100 + 16'(i));
        chk("R1 ready after drain", st_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_barrier();
        t_empty_barrier();
        t_same_addr();
        t_full();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule